// File: doc/BRIEF.md
# Chained Transmit Command Controller

This block sits between a host and a token-passing transmitter. The host posts transmit commands, each of which names a buffer page. The controller keeps up to `DEPTH` of these commands pending, two by default. Each time the token arrives and nothing is on the wire, it launches the oldest pending command. A later command therefore starts on a later token, just as if the host had issued it at that moment.

Each finished transmission produces a done flag and an acknowledged flag. The status path has two slots. One slot is visible to the host. The other holds a result that is waiting its turn. A visible result stays until the host issues a clear command. The held result is promoted only after the visible one has been cleared and the done line has then stayed low for a parameterised number of cycles, so two interrupts are always separated by an inactive gap.

The host interrupt is the done flag gated by an enable input. A drop command withdraws the oldest command that has not yet started.

Top module: `txc_ctrl`

## Requirements
- R1: After reset, `pend_cnt` is 0 and `tx_start`, `stat_done`, `stat_ack`, `stat_ovf` and `irq` are all low.
- R2: A command with `cmd_op` = 2'b01 (send), issued while `pend_cnt` < `DEPTH`, appends `cmd_page` to the queue. `pend_cnt` rises by one on the next cycle. `cmd_op` = 2'b00 does nothing.
- R3: A send issued while `pend_cnt` = `DEPTH` is ignored and sets `stat_ovf`. `stat_ovf` stays set until a clear command (`cmd_op` = 2'b10).
- R4: A transmission starts when `token_in` is high, nothing is in flight, the queue is not empty and no result is waiting in the held slot. On the next cycle `tx_start` pulses for one cycle and `tx_page` carries the oldest page. Pages start in the order they were queued, one per token.
- R5: `tx_done` while a transmission is in flight removes that entry from the queue. `tx_done` while nothing is in flight has no effect.
- R6: A completion sets `stat_done`, and `stat_ack` carries the `tx_ack` value of that completion. `stat_ack` is low whenever `stat_done` is low.
- R7: `stat_done` stays set until a clear command (2'b10), and it is low on the cycle after that command.
- R8: A result that completes while another is visible is held back. It becomes visible only after the visible result has been cleared and `stat_done` has then been low for at least `GAP_CYCLES` cycles.
- R9: `irq` equals `stat_done` AND `irq_en`. The acknowledged flag alone never raises `irq`.
- R10: A drop command (2'b11) removes the oldest command that has not started. While a transmission is in flight, the in-flight entry is kept and the next entry is removed instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command code: 00 none, 01 send, 10 clear, 11 drop |
| cmd_page | input | PAGE_W | Buffer page for a send command |
| token_in | input | 1 | Token received |
| tx_start | output | 1 | One-cycle transmission start pulse |
| tx_page | output | PAGE_W | Page of the started transmission |
| tx_done | input | 1 | Transmission finished |
| tx_ack | input | 1 | Finished transmission was acknowledged |
| irq_en | input | 1 | Interrupt enable for the done flag |
| stat_done | output | 1 | Visible transmit-done status |
| stat_ack | output | 1 | Visible acknowledged status |
| stat_ovf | output | 1 | Sticky send-overflow flag |
| pend_cnt | output | CNT_W | Commands queued, including the one in flight |
| irq | output | 1 | Host interrupt |

## Verification
Directed sequences come first.
- Two sends followed by a third separate a correct depth limit from a queue that overwrites or grows.
- Two back-to-back completions with opposite acknowledge values show whether the second result leaks past the first or arrives before the gap has elapsed.
- A drop before launch and a drop during flight tell apart a controller that removes the oldest entry from one that removes the newest or cancels the running transmission.
- A `tx_done` with nothing in flight catches a controller that pops its queue unconditionally.

A long run of mixed commands, tokens, completions and enable toggles then covers the overlaps. Examples are a clear and a completion in the same cycle, and a token arriving while both status slots are full.

// File: rtl/txc_pkg.sv
package txc_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_SEND = 2'b01,
      OP_CLR  = 2'b10,
      OP_DROP = 2'b11
   } txc_op_e;

endpackage

// File: rtl/txc_cmd_queue.sv
// Pending transmit commands, oldest at slot 0.
// Host edits are applied first, then the completion pop.
module txc_cmd_queue #(
   parameter int DEPTH  = 2,
   parameter int PAGE_W = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PAGE_W-1:0] push_page,
   input  logic              drop,
   input  logic              drop_skip_head,
   input  logic              pop,
   output logic              push_rejected,
   output logic [PAGE_W-1:0] head_after_cmd,
   output logic [CNT_W-1:0]  cnt_after_cmd,
   output logic [CNT_W-1:0]  count
);

   logic [PAGE_W-1:0] slot_q [DEPTH];
   logic [PAGE_W-1:0] slot_a [DEPTH];
   logic [PAGE_W-1:0] slot_n [DEPTH];
   logic [CNT_W-1:0]  cnt_q, cnt_a, cnt_n;
   logic [CNT_W-1:0]  victim;

   assign victim = drop_skip_head ? CNT_W'(1) : CNT_W'(0);

   always_comb begin
      slot_a        = slot_q;
      cnt_a         = cnt_q;
      push_rejected = 1'b0;
      if (push) begin
         if (cnt_q == CNT_W'(DEPTH)) begin
            push_rejected = 1'b1;
         end else begin
            for (int i = 0; i < DEPTH; i++) begin
               if (i == int'(cnt_q)) slot_a[i] = push_page;
            end
            cnt_a = cnt_q + CNT_W'(1);
         end
      end else if (drop && (cnt_q > victim)) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(victim)) slot_a[i] = slot_q[i+1];
         end
         cnt_a = cnt_q - CNT_W'(1);
      end
   end

   always_comb begin
      slot_n = slot_a;
      cnt_n  = cnt_a;
      if (pop && (cnt_a != '0)) begin
         for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot_a[i+1];
         cnt_n = cnt_a - CNT_W'(1);
      end
   end

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_n[g];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
   end

   assign head_after_cmd = slot_a[0];
   assign cnt_after_cmd  = cnt_a;
   assign count          = cnt_q;

endmodule

// File: rtl/txc_gap_timer.sv
// Counts the minimum inactive interval after the done flag is cleared.
module txc_gap_timer #(
   parameter int GAP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic idle
);

   generate
      if (GAP_CYCLES == 0) begin : g_nogap
         logic unused_gap0;
         assign unused_gap0 = ^{clk, rst_n, load};
         assign idle        = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(GAP_CYCLES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (load)           cnt_q <= CW'(GAP_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
         end
         assign idle = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/txc_stat_buf.sv
// Two-slot completion status: a visible slot and a held slot.
module txc_stat_buf (
   input  logic clk,
   input  logic rst_n,
   input  logic comp,
   input  logic comp_ack,
   input  logic clr,
   input  logic gap_idle,
   output logic done,
   output logic ack,
   output logic held,
   output logic clr_hit
);

   logic done_q, ack_q, held_q, hack_q;
   logic promote, direct;

   always_comb begin
      promote = !done_q && gap_idle && held_q;
      direct  = !done_q && gap_idle && !held_q && comp;
      clr_hit = clr && done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ack_q  <= 1'b0;
      end else if (clr_hit) begin
         done_q <= 1'b0;
         ack_q  <= 1'b0;
      end else if (promote || direct) begin
         done_q <= 1'b1;
         ack_q  <= promote ? hack_q : comp_ack;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         hack_q <= 1'b0;
      end else if (comp && !direct) begin
         held_q <= 1'b1;
         hack_q <= comp_ack;
      end else if (promote) begin
         held_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign ack  = ack_q;
   assign held = held_q;

endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl #(
   parameter int DEPTH      = 2,
   parameter int PAGE_W     = 4,
   parameter int GAP_CYCLES = 4,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic              token_in,
   output logic              tx_start,
   output logic [PAGE_W-1:0] tx_page,
   input  logic              tx_done,
   input  logic              tx_ack,
   input  logic              irq_en,
   output logic              stat_done,
   output logic              stat_ack,
   output logic              stat_ovf,
   output logic [CNT_W-1:0]  pend_cnt,
   output logic              irq
);
   import txc_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txc_ctrl: DEPTH must be at least 2");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("txc_ctrl: PAGE_W must be at least 1");
      end
      if (GAP_CYCLES < 0) begin : g_bad_gap
         $error("txc_ctrl: GAP_CYCLES must not be negative");
      end
   endgenerate

   txc_op_e op;
   logic    do_send, do_clr, do_drop;
   logic    in_flight_q, start_q;
   logic [PAGE_W-1:0] page_q;
   logic    ovf_q;
   logic    comp, launch;
   logic    rejected;
   logic [PAGE_W-1:0] head_pg;
   logic [CNT_W-1:0]  cnt_post, cnt_now;
   logic    done_w, ack_w, held_w, clr_hit_w, gap_idle_w;

   assign op      = txc_op_e'(cmd_op);
   assign do_send = cmd_valid && (op == OP_SEND);
   assign do_clr  = cmd_valid && (op == OP_CLR);
   assign do_drop = cmd_valid && (op == OP_DROP);
   assign comp    = in_flight_q && tx_done;

   txc_cmd_queue #(.DEPTH(DEPTH), .PAGE_W(PAGE_W)) u_queue (
      .clk            (clk),
      .rst_n          (rst_n),
      .push           (do_send),
      .push_page      (cmd_page),
      .drop           (do_drop),
      .drop_skip_head (in_flight_q),
      .pop            (comp),
      .push_rejected  (rejected),
      .head_after_cmd (head_pg),
      .cnt_after_cmd  (cnt_post),
      .count          (cnt_now)
   );

   assign launch = !in_flight_q && token_in && (cnt_post != '0) && !held_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_flight_q <= 1'b0;
         start_q     <= 1'b0;
         page_q      <= '0;
      end else begin
         start_q <= launch;
         if (launch) begin
            in_flight_q <= 1'b1;
            page_q      <= head_pg;
         end else if (comp) begin
            in_flight_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf_q <= 1'b0;
      else if (rejected) ovf_q <= 1'b1;
      else if (do_clr)   ovf_q <= 1'b0;
   end

   txc_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (clr_hit_w),
      .idle  (gap_idle_w)
   );

   txc_stat_buf u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .comp     (comp),
      .comp_ack (tx_ack),
      .clr      (do_clr),
      .gap_idle (gap_idle_w),
      .done     (done_w),
      .ack      (ack_w),
      .held     (held_w),
      .clr_hit  (clr_hit_w)
   );

   assign tx_start  = start_q;
   assign tx_page   = page_q;
   assign stat_done = done_w;
   assign stat_ack  = ack_w;
   assign stat_ovf  = ovf_q;
   assign pend_cnt  = cnt_now;
   assign irq       = done_w && irq_en;

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
   parameter int DEPTH      = 2,
   parameter int GAP_CYCLES = 4,
   parameter int CNT_W      = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic             tx_start,
   input logic             irq_en,
   input logic             stat_done,
   input logic             stat_ack,
   input logic             stat_ovf,
   input logic [CNT_W-1:0] pend_cnt,
   input logic             irq
);

   int   low_run;
   logic seen_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run   <= 0;
         seen_fall <= 1'b0;
      end else begin
         if (stat_done) low_run <= 0;
         else if (low_run < GAP_CYCLES + 2) low_run <= low_run + 1;
         if (!stat_done && low_run == 0) seen_fall <= seen_fall | 1'b0;
         if (stat_done) seen_fall <= 1'b1;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (pend_cnt == '0 && !stat_done && !stat_ovf)); // R1

   AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= CNT_W'(DEPTH)); // R2

   AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01 && pend_cnt == CNT_W'(DEPTH)) |=> stat_ovf); // R3

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R4

   AST_ACK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ack |-> stat_done); // R6

   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_done && !(cmd_valid && cmd_op == 2'b10)) |=> stat_done); // R7

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_done && cmd_valid && cmd_op == 2'b10) |=> !stat_done); // R7

   AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_done && !$past(stat_done) && seen_fall) |-> (low_run >= GAP_CYCLES)); // R8

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (stat_done && irq_en)); // R9

endmodule

bind txc_ctrl txc_checker #(
   .DEPTH      (DEPTH),
   .GAP_CYCLES (GAP_CYCLES),
   .CNT_W      (CNT_W)
) u_txc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .tx_start  (tx_start),
   .irq_en    (irq_en),
   .stat_done (stat_done),
   .stat_ack  (stat_ack),
   .stat_ovf  (stat_ovf),
   .pend_cnt  (pend_cnt),
   .irq       (irq)
);

// File: tb/tb_txc_ctrl.sv
module tb_txc_ctrl;

   localparam int DEPTH  = 2;
   localparam int PAGE_W = 4;
   localparam int GAP    = 4;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = 2'b00;
   logic [PAGE_W-1:0] cmd_page = '0;
   logic              token_in = 1'b0;
   logic              tx_done = 1'b0;
   logic              tx_ack = 1'b0;
   logic              irq_en = 1'b1;
   logic              tx_start, stat_done, stat_ack, stat_ovf, irq;
   logic [PAGE_W-1:0] tx_page;
   logic [CNT_W-1:0]  pend_cnt;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   txc_ctrl #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .GAP_CYCLES(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_page(cmd_page), .token_in(token_in), .tx_start(tx_start),
      .tx_page(tx_page), .tx_done(tx_done), .tx_ack(tx_ack), .irq_en(irq_en),
      .stat_done(stat_done), .stat_ack(stat_ack), .stat_ovf(stat_ovf),
      .pend_cnt(pend_cnt), .irq(irq)
   );

   // behavioural reference model
   int q[$];
   bit m_infl, m_txs, m_done, m_ack, m_hv, m_ha, m_ovf;
   int m_txp, m_gap;

   always @(posedge clk) begin
      bit comp, start, promote, direct, clr_hit, infl_old;
      if (!rst_n) begin
         q.delete();
         m_infl = 0; m_txs = 0; m_done = 0; m_ack = 0;
         m_hv = 0; m_ha = 0; m_ovf = 0; m_txp = 0; m_gap = 0;
      end else begin
         infl_old = m_infl;
         if (cmd_valid && cmd_op == 2'b01) begin
            if (q.size() < DEPTH) q.push_back(int'(cmd_page));
            else m_ovf = 1;
         end else if (cmd_valid && cmd_op == 2'b10) begin
            m_ovf = 0;
         end else if (cmd_valid && cmd_op == 2'b11) begin
            if (infl_old) begin
               if (q.size() > 1) q.delete(1);
            end else if (q.size() > 0) begin
               q.delete(0);
            end
         end
         start = !infl_old && token_in && q.size() > 0 && !m_hv;
         comp  = infl_old && tx_done;
         m_txs = start;
         if (start) begin
            m_txp  = q[0];
            m_infl = 1;
         end
         if (comp) begin
            void'(q.pop_front());
            m_infl = 0;
         end
         clr_hit = cmd_valid && cmd_op == 2'b10 && m_done;
         promote = !m_done && m_gap == 0 && m_hv;
         direct  = !m_done && m_gap == 0 && !m_hv && comp;
         if (clr_hit) begin
            m_done = 0; m_ack = 0;
         end else if (promote) begin
            m_done = 1; m_ack = m_ha;
         end else if (direct) begin
            m_done = 1; m_ack = tx_ack;
         end
         if (comp && !direct) begin
            m_hv = 1; m_ha = tx_ack;
         end else if (promote) begin
            m_hv = 0;
         end
         if (clr_hit) m_gap = GAP;
         else if (m_gap > 0) m_gap--;
      end
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      chk("R4 tx_start", int'(tx_start), int'(m_txs));
      if (m_txs) chk("R4 tx_page", int'(tx_page), m_txp);
      chk("R7 stat_done", int'(stat_done), int'(m_done));
      chk("R6 stat_ack", int'(stat_ack), int'(m_ack));
      chk("R3 stat_ovf", int'(stat_ovf), int'(m_ovf));
      chk("R2 pend_cnt", int'(pend_cnt), q.size());
      chk("R9 irq", int'(irq), int'(m_done && irq_en));
   endtask

   task automatic cyc(bit v, logic [1:0] op, int pg, bit tok, bit dn, bit ak);
      cmd_valid = v; cmd_op = op; cmd_page = PAGE_W'(pg);
      token_in = tok; tx_done = dn; tx_ack = ak;
      @(posedge clk);
      #2;
      compare_model();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 pend_cnt", int'(pend_cnt), 0);
      chk("R1 tx_start", int'(tx_start), 0);
      chk("R1 done/ack/ovf/irq", int'({stat_done, stat_ack, stat_ovf, irq}), 0);
      rst_n = 1'b1;
      idle(2);

      // R2 fill, R3 overflow and clear
      cyc(1, 2'b01, 5, 0, 0, 0);
      chk("R2 one queued", int'(pend_cnt), 1);
      cyc(1, 2'b00, 7, 0, 0, 0);
      chk("R2 nop ignored", int'(pend_cnt), 1);
      cyc(1, 2'b01, 9, 0, 0, 0);
      cyc(1, 2'b01, 3, 0, 0, 0);
      chk("R3 full send ignored", int'(pend_cnt), 2);
      chk("R3 ovf set", int'(stat_ovf), 1);
      cyc(1, 2'b10, 0, 0, 0, 0);
      chk("R3 ovf cleared", int'(stat_ovf), 0);

      // R4 ordered launch, R6/R8 double-buffered status
      cyc(0, 2'b00, 0, 1, 0, 0);
      chk("R4 start first", int'(tx_start), 1);
      chk("R4 first page", int'(tx_page), 5);
      cyc(0, 2'b00, 0, 1, 0, 0);
      chk("R4 no start in flight", int'(tx_start), 0);
      cyc(0, 2'b00, 0, 0, 1, 1);
      chk("R6 done set", int'(stat_done), 1);
      chk("R6 ack set", int'(stat_ack), 1);
      chk("R5 head popped", int'(pend_cnt), 1);
      cyc(0, 2'b00, 0, 1, 0, 0);
      chk("R4 second page", int'(tx_page), 9);
      cyc(0, 2'b00, 0, 0, 1, 0);
      chk("R8 first ack still shown", int'(stat_ack), 1);
      idle(3);
      chk("R7 done held", int'(stat_done), 1);
      cyc(1, 2'b10, 0, 0, 0, 0);
      chk("R7 clear drops done", int'(stat_done), 0);
      for (int i = 0; i < GAP; i++) begin
         idle(1);
         chk("R8 gap low", int'(stat_done), 0);
      end
      idle(1);
      chk("R8 held result shown", int'(stat_done), 1);
      chk("R8 held ack", int'(stat_ack), 0);
      irq_en = 1'b0;
      idle(1);
      chk("R9 masked irq", int'(irq), 0);
      irq_en = 1'b1;
      cyc(1, 2'b10, 0, 0, 0, 0);
      idle(GAP + 1);

      // R10 drop before and during flight
      cyc(1, 2'b01, 1, 0, 0, 0);
      cyc(1, 2'b01, 2, 0, 0, 0);
      cyc(1, 2'b11, 0, 0, 0, 0);
      chk("R10 drop oldest", int'(pend_cnt), 1);
      cyc(0, 2'b00, 0, 1, 0, 0);
      chk("R10 survivor launched", int'(tx_page), 2);
      cyc(1, 2'b01, 4, 0, 0, 0);
      cyc(1, 2'b11, 0, 0, 0, 0);
      chk("R10 in-flight kept", int'(pend_cnt), 1);
      cyc(0, 2'b00, 0, 0, 1, 1);
      chk("R10 queue empty", int'(pend_cnt), 0);
      cyc(1, 2'b10, 0, 0, 0, 0);
      idle(GAP + 1);

      // R5 spurious completion
      cyc(0, 2'b00, 0, 0, 1, 1);
      idle(1);
      chk("R5 spurious done ignored", int'(stat_done), 0);
      chk("R5 queue unchanged", int'(pend_cnt), 0);

      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int r;
         bit v;
         r = int'($urandom_range(0, 9));
         v = (r < 6);
         irq_en = ($urandom_range(0, 7) != 0);
         cyc(v, 2'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
             ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
             1'($urandom_range(0, 1)));
      end
      finish_run();
   end

endmodule